// File: doc/BRIEF.md
# Comparator Event Timer

This block keeps a free-running 64-bit tick counter and a set of comparator channels. Each channel watches the counter and flags an event when the counter reaches the channel's comparator value. The flag stays set until software clears it. Software programs everything through a 32-bit register port. A write takes effect on the clock edge where `bus_sel` and `bus_wr` are high. A read returns its data on `bus_rdata` one clock after the edge where `bus_sel` is high and `bus_wr` is low.

The counter is controlled by a two-state machine, HALT and RUN. A write to the global control word moves it from HALT to RUN when bit 0 is 1, and from RUN back to HALT when bit 0 is 0. Each channel has a three-state load sequencer that decides where a comparator write lands:
- OFF: writes go to the comparator. A configuration write with both periodic and load-sequence bits set moves it to CMP.
- CMP: writes go to the comparator. A low-half comparator write moves it to PER.
- PER: writes go to the period register. A low-half comparator write moves it back to OFF.
- From any state, a configuration write returns it to CMP if both bits are set, and to OFF otherwise.

A periodic channel adds its period to its comparator on every match. A one-shot channel leaves its comparator alone. Channel interrupt levels reach the outputs through a route field in each channel's configuration. A legacy option sends channel 0 and channel 1 to two dedicated lines instead.

Top module: `evt_timer`

## Requirements
- R1: After reset the counter is 0 and halted, the control word reads 0, all status bits and channel configurations are 0, every comparator reads all ones, and every interrupt output is low.
- R2: While running, the counter increases by exactly 1 per clock and carries from the low half into the high half. While halted, it holds its value.
- R3: Writes to the counter halves (low at 0x10, high at 0x14) load the counter only while it is halted. While it is running they are ignored.
- R4: A channel matches only when the counter equals its comparator. In 64-bit mode all 64 bits are compared. A match sets status bit n of the status word at 0x0C. A comparator below the current count produces no match, and no match occurs while the counter is halted.
- R5: A one-shot channel (configuration bit 1 = 0) keeps its comparator unchanged after a match.
- R6: A periodic channel (configuration bit 1 = 1) adds its period to the comparator on each match. It therefore matches again every period ticks without disturbing the counter.
- R7: Writing a channel configuration with bit 1 and bit 2 both set starts the load sequence, and bit 2 then reads 1. The first low-half comparator write loads the comparator. The second loads the period and clears bit 2. A high-half write goes to the same target as the low-half write that follows it.
- R8: Outside the load sequence, a comparator write changes only the comparator; the period is kept.
- R9: With configuration bit 3 set, only the low 32 bits are compared and reloaded. The comparator high half reads 0 and ignores writes.
- R10: Writing the status word clears each bit written as 1 and leaves bits written as 0. A status bit never clears without such a write.
- R11: An interrupt line (`irq_line`) goes high while any channel routed to it has its status set and its enable (configuration bit 0) set. The route index is in configuration bits [5:4].
- R12: With control bit 1 (legacy) set, channel 0 drives `irq_tick` and channel 1 drives `irq_rtc`, and neither drives `irq_line`. Channels 2 and up keep their routes. With legacy clear, `irq_tick` and `irq_rtc` are low.
- R13: The capability word at 0x00 holds revision 0x01 in bits [7:0], channel count minus one in [12:8], a 64-bit counter flag in bit 13 and a legacy-routing flag in bit 15. The word at 0x04 reads the tick period in femtoseconds, clamped to [100000, 100000000].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address; channel n at 0x20 + 16n (+0 config, +4 comparator low, +8 comparator high) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| irq_tick | output | 1 | Legacy system-tick interrupt (channel 0) |
| irq_rtc | output | 1 | Legacy real-time-clock interrupt (channel 1) |
| irq_line | output | NUM_IRQ | Routed interrupt lines |

## Verification
The bench builds the block with three channels and four routed lines. With three channels, one channel lies outside the legacy pair, so the test can show that a routed channel is unaffected while channels 0 and 1 are diverted. With four lines, the route field is two bits wide and the bench can place channels on separate lines. Because the counter can be loaded while halted, the bench can start it just below the 32-bit boundary. That brings the carry into the high half and the 32-bit comparison mode within a few dozen cycles. The same loading lets the bench place a 64-bit comparator behind the current count to show that nothing fires. Periodic reload and the load sequence are checked through the comparator value read back after a known number of counted ticks.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    typedef enum logic {
        CNT_HALT,
        CNT_RUN
    } cnt_state_e;

    typedef enum logic [1:0] {
        SV_OFF,
        SV_CMP,
        SV_PER
    } sv_state_e;

    // channel configuration bit positions
    localparam int CFG_IE  = 0;
    localparam int CFG_PER = 1;
    localparam int CFG_SV  = 2;
    localparam int CFG_M32 = 3;
    localparam int CFG_RT  = 4;

    // register addresses
    localparam logic [7:0] A_CAPS    = 8'h00;
    localparam logic [7:0] A_TICK    = 8'h04;
    localparam logic [7:0] A_GCFG    = 8'h08;
    localparam logic [7:0] A_ISR     = 8'h0C;
    localparam logic [7:0] A_CLO     = 8'h10;
    localparam logic [7:0] A_CHI     = 8'h14;
    localparam logic [7:0] A_CH0     = 8'h20;
    localparam logic [7:0] CH_STRIDE = 8'h10;
    localparam logic [7:0] OFF_CFG   = 8'h00;
    localparam logic [7:0] OFF_LO    = 8'h04;
    localparam logic [7:0] OFF_HI    = 8'h08;

    localparam logic [31:0] TICK_MIN = 32'd100_000;
    localparam logic [31:0] TICK_MAX = 32'd100_000_000;

    function automatic logic [7:0] ch_addr(input int idx, input logic [7:0] off);
        return A_CH0 + 8'(idx) * CH_STRIDE + off;
    endfunction

endpackage

// File: rtl/evt_counter.sv
module evt_counter
    import evt_timer_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_wr,
    input  logic            run_val,
    input  logic            lo_wr,
    input  logic            hi_wr,
    input  logic [DW-1:0]   wdata,
    output logic            running,
    output logic [2*DW-1:0] count
);
    cnt_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CNT_HALT;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CNT_HALT: if (run_wr && run_val)  st_d = CNT_RUN;
            CNT_RUN:  if (run_wr && !run_val) st_d = CNT_HALT;
            default:  st_d = CNT_HALT;
        endcase
    end

    always_comb running = (st_q == CNT_RUN);

    // R2, R3: count while running, accept loads only while halted
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (running) begin
            count <= count + 1'b1;
        end else begin
            if (lo_wr) count[DW-1:0]    <= wdata;
            if (hi_wr) count[2*DW-1:DW] <= wdata;
        end
    end
endmodule

// File: rtl/evt_channel.sv
module evt_channel
    import evt_timer_pkg::*;
#(
    parameter int DW   = 32,
    parameter int RT_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2*DW-1:0] count,
    input  logic            counting,
    input  logic            cfg_wr,
    input  logic            lo_wr,
    input  logic            hi_wr,
    input  logic            stat_clr,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   cfg_word,
    output logic [2*DW-1:0] cmp_word,
    output logic            stat,
    output logic            act,
    output logic [RT_W-1:0] route
);
    localparam int CW = 2 * DW;

    sv_state_e       sv_q, sv_d;
    logic            ie_q, per_q, m32_q;
    logic [RT_W-1:0] rt_q;
    logic [CW-1:0]   cmp_q, prd_q, reload;
    logic            hit, to_period, stat_q;

    // load-sequence state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sv_q <= SV_OFF;
        else        sv_q <= sv_d;
    end

    // R7: OFF -> CMP on config write, CMP -> PER -> OFF on low-half writes
    always_comb begin
        sv_d = sv_q;
        if (cfg_wr) begin
            sv_d = (wdata[CFG_PER] && wdata[CFG_SV]) ? SV_CMP : SV_OFF;
        end else begin
            unique case (sv_q)
                SV_OFF:  sv_d = SV_OFF;
                SV_CMP:  if (lo_wr) sv_d = SV_PER;
                SV_PER:  if (lo_wr) sv_d = SV_OFF;
                default: sv_d = SV_OFF;
            endcase
        end
    end

    always_comb begin
        to_period = (sv_q == SV_PER);
        reload    = cmp_q + prd_q;
        hit       = counting && (count[DW-1:0] == cmp_q[DW-1:0])
                    && (m32_q || (count[CW-1:DW] == cmp_q[CW-1:DW]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q  <= 1'b0;
            per_q <= 1'b0;
            m32_q <= 1'b0;
            rt_q  <= '0;
        end else if (cfg_wr) begin
            ie_q  <= wdata[CFG_IE];
            per_q <= wdata[CFG_PER];
            m32_q <= wdata[CFG_M32];
            rt_q  <= wdata[CFG_RT +: RT_W];
        end
    end

    // R5, R6, R8, R9: comparator writes win over periodic reload
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q <= '1;
            prd_q <= '0;
        end else begin
            if (lo_wr && !to_period)      cmp_q[DW-1:0] <= wdata;
            else if (hit && per_q)        cmp_q[DW-1:0] <= reload[DW-1:0];

            if (hi_wr && !to_period && !m32_q)  cmp_q[CW-1:DW] <= wdata;
            else if (hit && per_q && !m32_q)    cmp_q[CW-1:DW] <= reload[CW-1:DW];

            if (lo_wr && to_period) prd_q[DW-1:0]  <= wdata;
            if (hi_wr && to_period) prd_q[CW-1:DW] <= wdata;
        end
    end

    // R4, R10: match sets, write-one clears, set wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        stat_q <= 1'b0;
        else if (hit)      stat_q <= 1'b1;
        else if (stat_clr) stat_q <= 1'b0;
    end

    always_comb begin
        cfg_word                 = '0;
        cfg_word[CFG_IE]         = ie_q;
        cfg_word[CFG_PER]        = per_q;
        cfg_word[CFG_SV]         = (sv_q != SV_OFF);
        cfg_word[CFG_M32]        = m32_q;
        cfg_word[CFG_RT +: RT_W] = rt_q;
        cmp_word = {(m32_q ? {DW{1'b0}} : cmp_q[CW-1:DW]), cmp_q[DW-1:0]};
        stat     = stat_q;
        act      = stat_q & ie_q;
        route    = rt_q;
    end
endmodule

// File: rtl/evt_irq_route.sv
module evt_irq_route #(
    parameter int NUM_CH  = 3,
    parameter int NUM_IRQ = 4,
    parameter int RT_W    = 2
) (
    input  logic [NUM_CH-1:0]      act,
    input  logic [NUM_CH*RT_W-1:0] route,
    input  logic                   legacy,
    output logic                   irq_tick,
    output logic                   irq_rtc,
    output logic [NUM_IRQ-1:0]     irq_line
);
    // R11, R12
    always_comb begin
        for (int l = 0; l < NUM_IRQ; l++) begin
            irq_line[l] = 1'b0;
            for (int c = 0; c < NUM_CH; c++) begin
                if (act[c] && (route[c*RT_W +: RT_W] == RT_W'(l)) && !(legacy && c < 2))
                    irq_line[l] = 1'b1;
            end
        end
        irq_tick = legacy & act[0];
        irq_rtc  = legacy & act[1];
    end
endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_timer_pkg::*;
#(
    parameter int          NUM_CH  = 3,
    parameter int          NUM_IRQ = 4,
    parameter logic [31:0] TICK_FS = 32'd69841279
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [7:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               irq_tick,
    output logic               irq_rtc,
    output logic [NUM_IRQ-1:0] irq_line
);
    localparam int DW   = 32;
    localparam int RT_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
    localparam logic [DW-1:0] TICK_RPT =
        (TICK_FS < TICK_MIN) ? TICK_MIN : ((TICK_FS > TICK_MAX) ? TICK_MAX : TICK_FS);
    localparam logic [DW-1:0] CAPS_WORD =
        {16'h0, 1'b1, 1'b0, 1'b1, 5'(NUM_CH - 1), 8'h01};

    logic                   wr_s, gcfg_wr, isr_wr, cnt_lo_wr, cnt_hi_wr;
    logic                   legacy_q, cnt_running;
    logic [2*DW-1:0]        cnt_val;
    logic [NUM_CH-1:0]      ch_stat, ch_act;
    logic [NUM_CH*RT_W-1:0] ch_route;
    logic [DW-1:0]          ch_cfg [NUM_CH];
    logic [2*DW-1:0]        ch_cmp [NUM_CH];
    logic [DW-1:0]          rd_d;

    always_comb begin
        wr_s      = bus_sel & bus_wr;
        gcfg_wr   = wr_s && (bus_addr == A_GCFG);
        isr_wr    = wr_s && (bus_addr == A_ISR);
        cnt_lo_wr = wr_s && (bus_addr == A_CLO);
        cnt_hi_wr = wr_s && (bus_addr == A_CHI);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       legacy_q <= 1'b0;
        else if (gcfg_wr) legacy_q <= bus_wdata[1];
    end

    evt_counter #(.DW(DW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_wr  (gcfg_wr),
        .run_val (bus_wdata[0]),
        .lo_wr   (cnt_lo_wr),
        .hi_wr   (cnt_hi_wr),
        .wdata   (bus_wdata),
        .running (cnt_running),
        .count   (cnt_val)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam logic [7:0] BASE = ch_addr(g, 8'h00);
        logic cfg_wr_s, lo_wr_s, hi_wr_s;
        always_comb begin
            cfg_wr_s = wr_s && (bus_addr == BASE + OFF_CFG);
            lo_wr_s  = wr_s && (bus_addr == BASE + OFF_LO);
            hi_wr_s  = wr_s && (bus_addr == BASE + OFF_HI);
        end
        evt_channel #(.DW(DW), .RT_W(RT_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .count    (cnt_val),
            .counting (cnt_running),
            .cfg_wr   (cfg_wr_s),
            .lo_wr    (lo_wr_s),
            .hi_wr    (hi_wr_s),
            .stat_clr (isr_wr && bus_wdata[g]),
            .wdata    (bus_wdata),
            .cfg_word (ch_cfg[g]),
            .cmp_word (ch_cmp[g]),
            .stat     (ch_stat[g]),
            .act      (ch_act[g]),
            .route    (ch_route[g*RT_W +: RT_W])
        );
    end

    evt_irq_route #(.NUM_CH(NUM_CH), .NUM_IRQ(NUM_IRQ), .RT_W(RT_W)) u_route (
        .act      (ch_act),
        .route    (ch_route),
        .legacy   (legacy_q),
        .irq_tick (irq_tick),
        .irq_rtc  (irq_rtc),
        .irq_line (irq_line)
    );

    // read multiplexer (R13 words, R1 reset view)
    always_comb begin
        rd_d = '0;
        case (bus_addr)
            A_CAPS:  rd_d = CAPS_WORD;
            A_TICK:  rd_d = TICK_RPT;
            A_GCFG:  rd_d = {{(DW-2){1'b0}}, legacy_q, cnt_running};
            A_ISR:   rd_d = DW'(ch_stat);
            A_CLO:   rd_d = cnt_val[DW-1:0];
            A_CHI:   rd_d = cnt_val[2*DW-1:DW];
            default: rd_d = '0;
        endcase
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == ch_addr(i, OFF_CFG)) rd_d = ch_cfg[i];
            if (bus_addr == ch_addr(i, OFF_LO))  rd_d = ch_cmp[i][DW-1:0];
            if (bus_addr == ch_addr(i, OFF_HI))  rd_d = ch_cmp[i][2*DW-1:DW];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                bus_rdata <= '0;
        else if (bus_sel && !bus_wr) bus_rdata <= rd_d;
    end
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
    parameter int NUM_CH  = 3,
    parameter int NUM_IRQ = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               running,
    input logic [63:0]        count,
    input logic [NUM_CH-1:0]  stat,
    input logic [NUM_CH-1:0]  act,
    input logic               legacy,
    input logic               isr_wr,
    input logic               cnt_lo_wr,
    input logic               cnt_hi_wr,
    input logic               irq_tick,
    input logic               irq_rtc,
    input logic [NUM_IRQ-1:0] irq_line
);
    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> count == $past(count) + 64'd1);

    assert_halt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !cnt_lo_wr && !cnt_hi_wr) |=> $stable(count));

    assert_no_match_halted_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> (stat & ~$past(stat)) == '0);

    assert_stat_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !isr_wr |=> (stat & $past(stat)) == $past(stat));

    assert_line_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_line != '0) |-> (act != '0));

    assert_legacy_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !legacy |-> (!irq_tick && !irq_rtc));
endmodule

bind evt_timer evt_timer_chk #(.NUM_CH(NUM_CH), .NUM_IRQ(NUM_IRQ)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .running   (cnt_running),
    .count     (cnt_val),
    .stat      (ch_stat),
    .act       (ch_act),
    .legacy    (legacy_q),
    .isr_wr    (isr_wr),
    .cnt_lo_wr (cnt_lo_wr),
    .cnt_hi_wr (cnt_hi_wr),
    .irq_tick  (irq_tick),
    .irq_rtc   (irq_rtc),
    .irq_line  (irq_line)
);

// File: tb/evt_timer_test.sv
module evt_timer_test;
    localparam int          NCH  = 3;
    localparam int          NIRQ = 4;
    localparam logic [31:0] TICK = 32'd69841279;
    localparam logic [31:0] CAPS_EXP = {16'h0, 1'b1, 1'b0, 1'b1, 5'(NCH - 1), 8'h01};
    localparam logic [7:0]  GCFG = 8'h08, ISR = 8'h0C, CLO = 8'h10, CHI = 8'h14;
    localparam logic [7:0]  C0 = 8'h20, C1 = 8'h30, C2 = 8'h40;

    logic            clk = 1'b0;
    logic            rst_n, bus_sel, bus_wr;
    logic [7:0]      bus_addr;
    logic [31:0]     bus_wdata, bus_rdata;
    logic            irq_tick, irq_rtc;
    logic [NIRQ-1:0] irq_line;
    int              checks = 0;
    int              errors = 0;
    bit              done = 1'b0;

    always #10 clk = ~clk;

    evt_timer #(.NUM_CH(NCH), .NUM_IRQ(NIRQ), .TICK_FS(TICK)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_tick(irq_tick), .irq_rtc(irq_rtc), .irq_line(irq_line)
    );

    typedef struct packed {
        logic        rd;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 16;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, GCFG,     32'h0,        4'd1},   // R1 control word
        '{1'b1, CLO,      32'h0,        4'd1},   // R1 counter low
        '{1'b1, CHI,      32'h0,        4'd1},   // R1 counter high
        '{1'b1, ISR,      32'h0,        4'd1},   // R1 status
        '{1'b1, C0 + 8'h4, 32'hFFFF_FFFF, 4'd1}, // R1 comparator low
        '{1'b1, C2 + 8'h8, 32'hFFFF_FFFF, 4'd1}, // R1 comparator high
        '{1'b1, C1,       32'h0,        4'd1},   // R1 config
        '{1'b1, 8'h00,    CAPS_EXP,     4'd13},  // R13 capability
        '{1'b1, 8'h04,    TICK,         4'd13},  // R13 tick period
        '{1'b0, CLO,      32'hDEAD_0000, 4'd3},
        '{1'b0, CHI,      32'h0000_0042, 4'd3},
        '{1'b1, CLO,      32'hDEAD_0000, 4'd3},  // R3 load while halted
        '{1'b1, CHI,      32'h0000_0042, 4'd3},
        '{1'b0, CLO,      32'h0,        4'd3},
        '{1'b0, CHI,      32'h0,        4'd3},
        '{1'b1, CHI,      32'h0,        4'd3}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] d;
        rd(a, d);
        check(tag, d, exp);
    endtask

    // counts n+1 ticks; matches counter values start .. start+n
    task automatic run_for(input int n);
        wr(GCFG, 32'h1);
        repeat (n) @(negedge clk);
        wr(GCFG, 32'h0);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] d;
        rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 outputs after reset
        check("R1 irq_line", 32'(irq_line), 32'h0);
        check("R1 irq_tick/rtc", {30'h0, irq_tick, irq_rtc}, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i].rd) begin
                rd(VEC[i].addr, d);
                check($sformatf("R%0d vector %0d", VEC[i].req, i), d, VEC[i].data);
            end else begin
                wr(VEC[i].addr, VEC[i].data);
            end
        end
        // R13 range
        check("R13 tick in range", 32'(TICK >= 32'd100_000 && TICK <= 32'd100_000_000), 32'h1);

        // R3: load ignored while running; R2 counting and hold
        wr(CLO, 32'd100);
        wr(GCFG, 32'h1);
        wr(CLO, 32'h0);
        wr(GCFG, 32'h0);
        rd_chk(CLO, 32'd102, "R3 write ignored while running");
        repeat (5) @(negedge clk);
        rd_chk(CLO, 32'd102, "R2 hold while halted");
        run_for(49);
        rd_chk(CLO, 32'd152, "R2 one per clock");

        // R4/R5 one-shot on channel 0
        wr(CLO, 32'h0); wr(CHI, 32'h0);
        wr(C0, 32'h1);
        wr(C0 + 8'h4, 32'd10); wr(C0 + 8'h8, 32'h0);
        run_for(4);
        rd_chk(ISR, 32'h0, "R4 no match before comparator");
        run_for(20);
        rd_chk(ISR, 32'h1, "R4 match on equality");
        check("R11 routed line 0", 32'(irq_line), 32'h1);
        rd_chk(C0 + 8'h4, 32'd10, "R5 one-shot comparator kept");
        wr(ISR, 32'h1);
        rd_chk(ISR, 32'h0, "R10 write-one clears");
        run_for(50);
        rd_chk(ISR, 32'h0, "R4 past comparator silent");

        // R7 load sequence, R6 periodic reload
        wr(CLO, 32'h0); wr(CHI, 32'h0);
        wr(C0, 32'h7);
        rd_chk(C0, 32'h7, "R7 sequence bit set");
        wr(C0 + 8'h8, 32'h0); wr(C0 + 8'h4, 32'd10);
        rd_chk(C0, 32'h7, "R7 bit held after first write");
        wr(C0 + 8'h8, 32'h0); wr(C0 + 8'h4, 32'd25);
        rd_chk(C0, 32'h3, "R7 bit clears after second write");
        rd_chk(C0 + 8'h4, 32'd10, "R7 first write is comparator");
        wr(ISR, 32'h7);
        run_for(99);
        rd_chk(C0 + 8'h4, 32'd110, "R6 periodic reload");
        rd_chk(CLO, 32'd100, "R6 counter not reset by match");
        rd_chk(ISR, 32'h1, "R6 status from periodic match");

        // R8 plain write keeps period
        wr(C0 + 8'h4, 32'd130);
        rd_chk(C0, 32'h3, "R8 config unchanged");
        run_for(49);
        rd_chk(C0 + 8'h4, 32'd155, "R8 period kept");

        // R10 zero leaves bit
        wr(ISR, 32'h0);
        rd_chk(ISR, 32'h1, "R10 zero write keeps bit");
        wr(ISR, 32'h1);
        rd_chk(ISR, 32'h0, "R10 one write clears bit");

        // R9 32-bit mode on channel 2, route 2
        wr(C2, 32'h29);
        wr(C2 + 8'h4, 32'd5); wr(C2 + 8'h8, 32'hAB);
        rd_chk(C2 + 8'h8, 32'h0, "R9 high half reads zero");
        wr(CLO, 32'hFFFF_FFF0); wr(CHI, 32'h0);
        run_for(29);
        rd_chk(ISR, 32'h4, "R9 low-half match across wrap");
        check("R11 routed line 2", 32'(irq_line), 32'h4);
        rd_chk(CHI, 32'h1, "R2 carry into high half");
        rd_chk(CLO, 32'h0E, "R2 low half after carry");

        // R12 legacy routing
        wr(C1, 32'h31);
        wr(C1 + 8'h4, 32'h20); wr(C1 + 8'h8, 32'h1);
        wr(C0, 32'h1);
        wr(C0 + 8'h4, 32'h30); wr(C0 + 8'h8, 32'h1);
        run_for(40);
        rd_chk(ISR, 32'h7, "R4 64-bit matches");
        check("R11 lines without legacy", 32'(irq_line), 32'hD);
        check("R12 legacy lines quiet", {30'h0, irq_tick, irq_rtc}, 32'h0);
        wr(GCFG, 32'h2);
        rd_chk(GCFG, 32'h2, "R12 legacy bit readback");
        check("R12 legacy tick+rtc", {30'h0, irq_tick, irq_rtc}, 32'h3);
        check("R12 channel 2 keeps route", 32'(irq_line), 32'h4);
        wr(ISR, 32'h1);
        check("R12 tick follows channel 0", {30'h0, irq_tick, irq_rtc}, 32'h1);

        done = 1'b1;
        finish_run();
    end
endmodule